// File: doc/BRIEF.md
# Command/Response Bus Controller Word Transmitter

This block is the transmit half of a bus controller on a command/response serial bus that runs at 1 Mbps. When asked to perform a controller-to-terminal transfer, it assembles a command word from the terminal address, subaddress and word count. It then serializes that command word and two payload data words back to back onto one Manchester-coded line. After the last word it releases the line and waits for the terminal's status word. The receive path reports that status word through a one-cycle indication.

Every word occupies 20 bit times. The first three bit times hold a sync pattern whose polarity tells command/status words from data words. Sixteen Manchester-coded bits follow, most significant first, and the word closes with an odd-parity bit. The half-bit cell pace is divided down from the 50 MHz system clock. One cell counter serves all word kinds. If no status word arrives within a programmable number of half-bit cells, the block raises a no-response flag and returns to idle.

Top module: `bcx_xfer_tx`

## Requirements
- R1: While reset is asserted and right after it, line_en, line_out, busy, xfer_ok and no_resp_err are all 0.
- R2: Each half-bit cell lasts SYS_CLK_HZ/(2*BIT_HZ) system clocks (25 by default). The first cell starts on the clock edge that accepts start. A word is 40 cells, and the line level changes only on cell boundaries.
- R3: The sync field is the first 6 cells of a word. For a command word the line is high for 3 cells and then low for 3. For a data word it is low for 3 cells and then high for 3.
- R4: After the sync, 16 word bits go out most significant first, 2 cells per bit. A 1 is sent high then low, and a 0 is sent low then high.
- R5: The last 2 cells of every word carry an odd-parity bit, chosen so that the 16 word bits plus parity hold an odd count of ones. It is Manchester-coded like R4.
- R6: The command word holds rt_addr in bits 15:11 and a 0 in bit 10 (terminal receives). It holds sub_addr in bits 9:5 and word_cnt in bits 4:0.
- R7: A transfer sends, with no gap, the command word, then payload[15:0], then payload[31:16]. line_en is high for exactly those 120 cells. line_out is 0 whenever line_en is 0.
- R8: start is accepted only while busy is 0. A start pulse during a transfer changes neither the words sent nor the timing. The fields and payload are captured on the accepting edge.
- R9: After the last cell the block waits with busy high. status_rcvd during the wait ends the transfer: xfer_ok pulses for one cycle and busy is 0 in that same cycle. status_rcvd while words are being sent is ignored.
- R10: If no status arrives within resp_limit half-bit cells (25*resp_limit clocks) after the last cell ends, no_resp_err goes to 1 and busy to 0 on that edge. A resp_limit of 0 means wait forever. no_resp_err holds until the next accepted start clears it.
- R11: If status_rcvd is sampled on the same edge on which the timeout would expire, the status wins: xfer_ok pulses and no_resp_err stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 50 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a controller-to-terminal transfer |
| rt_addr | input | 5 | Terminal address for the command word |
| sub_addr | input | 5 | Subaddress for the command word |
| word_cnt | input | 5 | Word count field for the command word |
| payload | input | 32 | Two data words; the low half is sent first |
| status_rcvd | input | 1 | One-cycle pulse from the receiver on a valid status word |
| resp_limit | input | 16 | Response timeout in half-bit cells, 0 = none |
| line_out | output | 1 | Manchester-coded serial line level |
| line_en | output | 1 | Line driver enable, high while words are sent |
| busy | output | 1 | Transfer in progress (sending or awaiting status) |
| xfer_ok | output | 1 | One-cycle pulse when the status word ends the transfer |
| no_resp_err | output | 1 | Sticky flag: the terminal did not answer in time |

## Verification
The scoreboard predicts every one of the 120 cell levels per transfer. A swapped sync polarity, an inverted Manchester phase, an even-parity bit, a reversed bit order or a misplaced command field therefore each cause a miscompare in a known cell. The payloads include words with even and odd counts of ones and all-ones and all-zeros words, so a parity that is stuck, or a parity taken over the wrong span, shows up. A status pulse and a second start are injected in the middle of sending. A design that listened to either would cut the transfer short or restart it with different data. The timeout is probed one cycle before and one cycle after its expiry edge, and a status pulse is landed on that very edge. This catches an off-by-one timeout counter, a counter that counts system clocks instead of cells, and a timeout that wins over the status.

// File: rtl/bcx_pkg.sv
package bcx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SEND = 2'd1,
      ST_WAIT = 2'd2
   } bcx_state_e;

   typedef enum logic {
      WK_CMD  = 1'b0,
      WK_DATA = 1'b1
   } bcx_kind_e;

   // Sync level for a cell of the sync field; first_part selects the leading half.
   function automatic logic sync_level(input bcx_kind_e kind, input logic first_part);
      return (kind == WK_CMD) ? first_part : ~first_part;
   endfunction

endpackage

// File: rtl/bcx_half_tick.sv
module bcx_half_tick #(
   parameter int HALF_CLKS = 25
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int TK_W = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;

   generate
      if (HALF_CLKS == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         logic [TK_W-1:0] cnt;
         logic            at_end;

         assign at_end = (cnt == TK_W'(HALF_CLKS - 1));
         assign tick   = run & at_end;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (!run) begin
               cnt <= '0;
            end else if (at_end) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/bcx_word_enc.sv
module bcx_word_enc
   import bcx_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int SYNC_BITS = 3,
   parameter int CELL_W    = 6
) (
   input  bcx_kind_e         kind,
   input  logic [DATA_W-1:0] word,
   input  logic [CELL_W-1:0] cell_idx,
   output logic              level
);
   localparam int SYNC_H = 2 * SYNC_BITS;

   logic              par_bit;
   logic [CELL_W-1:0] body_idx;
   logic [CELL_W-2:0] bit_pos;
   logic              bit_val;

   assign par_bit  = ~(^word);
   assign body_idx = cell_idx - CELL_W'(SYNC_H);
   assign bit_pos  = body_idx[CELL_W-1:1];

   always_comb begin
      bit_val = par_bit;
      if (int'(bit_pos) < DATA_W) begin
         bit_val = word[DATA_W - 1 - int'(bit_pos)];
      end
      if (cell_idx < CELL_W'(SYNC_H)) begin
         level = sync_level(kind, cell_idx < CELL_W'(SYNC_BITS));
      end else begin
         level = bit_val ^ body_idx[0];
      end
   end

endmodule

// File: rtl/bcx_xfer_seq.sv
module bcx_xfer_seq
   import bcx_pkg::*;
#(
   parameter int CELLS   = 40,
   parameter int CELL_W  = 6,
   parameter int N_WORDS = 3,
   parameter int WIDX_W  = 2,
   parameter int TO_W    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              status_rcvd,
   input  logic              tick,
   input  logic [TO_W-1:0]   resp_limit,
   output bcx_state_e        state,
   output logic [WIDX_W-1:0] word_idx,
   output logic [CELL_W-1:0] cell_idx,
   output logic              accept,
   output logic              xfer_ok,
   output logic              no_resp
);
   logic [TO_W-1:0] wait_cnt;
   logic            last_cell;
   logic            last_word;
   logic            expire;

   assign accept    = (state == ST_IDLE) & start;
   assign last_cell = (cell_idx == CELL_W'(CELLS - 1));
   assign last_word = (word_idx == WIDX_W'(N_WORDS - 1));
   assign expire    = tick & (({1'b0, wait_cnt} + 1'b1) == {1'b0, resp_limit});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         word_idx <= '0;
         cell_idx <= '0;
         wait_cnt <= '0;
         xfer_ok  <= 1'b0;
         no_resp  <= 1'b0;
      end else begin
         xfer_ok <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  state    <= ST_SEND;
                  word_idx <= '0;
                  cell_idx <= '0;
                  no_resp  <= 1'b0;
               end
            end
            ST_SEND: begin
               if (tick) begin
                  if (last_cell) begin
                     cell_idx <= '0;
                     if (last_word) begin
                        state    <= ST_WAIT;
                        wait_cnt <= '0;
                     end else begin
                        word_idx <= word_idx + 1'b1;
                     end
                  end else begin
                     cell_idx <= cell_idx + 1'b1;
                  end
               end
            end
            ST_WAIT: begin
               if (status_rcvd) begin
                  state   <= ST_IDLE;
                  xfer_ok <= 1'b1;
               end else if (expire) begin
                  state   <= ST_IDLE;
                  no_resp <= 1'b1;
               end else if (tick) begin
                  wait_cnt <= wait_cnt + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/bcx_xfer_tx.sv
module bcx_xfer_tx
   import bcx_pkg::*;
#(
   parameter int SYS_CLK_HZ = 50_000_000,
   parameter int BIT_HZ     = 1_000_000,
   parameter int ADDR_W     = 5,
   parameter int SUB_W      = 5,
   parameter int CNT_W      = 5,
   parameter int N_DATA     = 2,
   parameter int SYNC_BITS  = 3,
   parameter int TO_W       = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic [ADDR_W-1:0]          rt_addr,
   input  logic [SUB_W-1:0]           sub_addr,
   input  logic [CNT_W-1:0]           word_cnt,
   input  logic [N_DATA*(ADDR_W+SUB_W+CNT_W+1)-1:0] payload,
   input  logic                       status_rcvd,
   input  logic [TO_W-1:0]            resp_limit,
   output logic                       line_out,
   output logic                       line_en,
   output logic                       busy,
   output logic                       xfer_ok,
   output logic                       no_resp_err
);
   localparam int DATA_W    = ADDR_W + 1 + SUB_W + CNT_W;
   localparam int HALF_CLKS = SYS_CLK_HZ / (2 * BIT_HZ);
   localparam int SYNC_H    = 2 * SYNC_BITS;
   localparam int CELLS     = SYNC_H + 2 * (DATA_W + 1);
   localparam int CELL_W    = $clog2(CELLS);
   localparam int N_WORDS   = 1 + N_DATA;
   localparam int WIDX_W    = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

   generate
      if (SYS_CLK_HZ % (2 * BIT_HZ) != 0) begin : g_bad_clk
         $error("system clock is not an integer multiple of the half-bit rate");
      end
      if (HALF_CLKS < 1) begin : g_bad_half
         $error("half-bit cell must be at least one system clock");
      end
      if (N_DATA < 1) begin : g_bad_ndata
         $error("a transfer carries at least one data word");
      end
      if (SYNC_BITS < 1) begin : g_bad_sync
         $error("sync field needs at least one bit time");
      end
      if (TO_W < 1) begin : g_bad_to
         $error("timeout counter needs at least one bit");
      end
   endgenerate

   bcx_state_e        state;
   logic [WIDX_W-1:0] word_idx;
   logic [CELL_W-1:0] cell_idx;
   logic              accept;
   logic              tick;
   logic              enc_level;
   logic [DATA_W-1:0] cmd_word;
   logic [DATA_W-1:0] bank [N_WORDS];
   logic [DATA_W-1:0] cur_word;
   bcx_kind_e         cur_kind;

   assign cmd_word = {rt_addr, 1'b0, sub_addr, word_cnt};

   // Word bank captured on the accepting edge; entry 0 is the command word.
   generate
      for (genvar gi = 0; gi < N_WORDS; gi++) begin : g_bank
         if (gi == 0) begin : g_cmd
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  bank[gi] <= '0;
               end else if (accept) begin
                  bank[gi] <= cmd_word;
               end
            end
         end else begin : g_dat
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  bank[gi] <= '0;
               end else if (accept) begin
                  bank[gi] <= payload[(gi-1)*DATA_W +: DATA_W];
               end
            end
         end
      end
   endgenerate

   assign cur_word = bank[word_idx];
   assign cur_kind = (word_idx == '0) ? WK_CMD : WK_DATA;

   bcx_half_tick #(
      .HALF_CLKS (HALF_CLKS)
   ) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy),
      .tick  (tick)
   );

   bcx_xfer_seq #(
      .CELLS   (CELLS),
      .CELL_W  (CELL_W),
      .N_WORDS (N_WORDS),
      .WIDX_W  (WIDX_W),
      .TO_W    (TO_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .status_rcvd (status_rcvd),
      .tick        (tick),
      .resp_limit  (resp_limit),
      .state       (state),
      .word_idx    (word_idx),
      .cell_idx    (cell_idx),
      .accept      (accept),
      .xfer_ok     (xfer_ok),
      .no_resp     (no_resp_err)
   );

   bcx_word_enc #(
      .DATA_W    (DATA_W),
      .SYNC_BITS (SYNC_BITS),
      .CELL_W    (CELL_W)
   ) u_enc (
      .kind     (cur_kind),
      .word     (cur_word),
      .cell_idx (cell_idx),
      .level    (enc_level)
   );

   assign busy     = (state != ST_IDLE);
   assign line_en  = (state == ST_SEND);
   assign line_out = line_en & enc_level;

endmodule

// File: rtl/bcx_xfer_chk.sv
module bcx_xfer_chk #(
   parameter int HALF_CLKS = 25
) (
   input logic clk,
   input logic rst_n,
   input logic line_out,
   input logic line_en,
   input logic busy,
   input logic xfer_ok,
   input logic no_resp_err
);
   localparam int PH_W = $clog2(HALF_CLKS + 1);

   logic [PH_W-1:0] ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph <= '0;
      end else if (!line_en) begin
         ph <= '0;
      end else if (ph == PH_W'(HALF_CLKS - 1)) begin
         ph <= '0;
      end else begin
         ph <= ph + 1'b1;
      end
   end

   // R2
   cell_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_en && $past(line_en) && !$stable(line_out)) |-> (ph == '0));

   // R7
   quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !line_en |-> !line_out);

   // R8
   idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_en) |-> !$past(busy));

   // R9
   ok_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_ok |-> !busy);

   // R10
   err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(no_resp_err) |-> !busy);

   // R11
   ok_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_ok |-> !no_resp_err);

endmodule

bind bcx_xfer_tx bcx_xfer_chk #(
   .HALF_CLKS (HALF_CLKS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .line_out    (line_out),
   .line_en     (line_en),
   .busy        (busy),
   .xfer_ok     (xfer_ok),
   .no_resp_err (no_resp_err)
);

// File: tb/bcx_xfer_tx_tb.sv
module bcx_xfer_tx_tb;
   localparam int HALF = 25;
   localparam int WORD_CELLS = 40;
   localparam int XFER_CELLS = 3 * WORD_CELLS;
   localparam int XFER_CLKS = XFER_CELLS * HALF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [4:0]  rt_addr = '0;
   logic [4:0]  sub_addr = '0;
   logic [4:0]  word_cnt = '0;
   logic [31:0] payload = '0;
   logic        status_rcvd = 1'b0;
   logic [15:0] resp_limit = '0;
   logic        line_out, line_en, busy, xfer_ok, no_resp_err;

   int n_chk = 0;
   int n_bad = 0;
   logic exp_q[$];

   always #10 clk = ~clk;

   bcx_xfer_tx u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .rt_addr     (rt_addr),
      .sub_addr    (sub_addr),
      .word_cnt    (word_cnt),
      .payload     (payload),
      .status_rcvd (status_rcvd),
      .resp_limit  (resp_limit),
      .line_out    (line_out),
      .line_en     (line_en),
      .busy        (busy),
      .xfer_ok     (xfer_ok),
      .no_resp_err (no_resp_err)
   );

   task automatic check(input logic ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // Expected cells of one word: sync (R3), bits MSB first (R4), odd parity (R5).
   task automatic push_word(input logic is_cmd, input logic [15:0] w);
      logic p;
      for (int i = 0; i < 6; i++) exp_q.push_back(is_cmd ? (i < 3) : (i >= 3));
      for (int b = 15; b >= 0; b--) begin
         exp_q.push_back(w[b]);
         exp_q.push_back(~w[b]);
      end
      p = ~(^w);
      exp_q.push_back(p);
      exp_q.push_back(~p);
   endtask

   // Driver: predicts the transfer (R6, R7), then pulses start. Returns half a clock after the accept edge.
   task automatic drive_xfer(input logic [4:0] a, input logic [4:0] s, input logic [4:0] c,
                             input logic [15:0] d0, input logic [15:0] d1, input logic [15:0] lim);
      push_word(1'b1, {a, 1'b0, s, c});
      push_word(1'b0, d0);
      push_word(1'b0, d1);
      @(negedge clk);
      rt_addr = a; sub_addr = s; word_cnt = c; payload = {d1, d0}; resp_limit = lim;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // Monitor: samples the middle of every cell of a transfer (R2, R3, R4, R5, R6, R7).
   initial begin
      forever begin
         @(posedge line_en);
         repeat (HALF / 2) @(negedge clk);
         for (int k = 0; k < XFER_CELLS; k++) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R7 unexpected cell", int'(line_out), -1);
            end else begin
               logic e;
               e = exp_q.pop_front();
               check(line_en === 1'b1 && line_out === e, "R2/R3/R4/R5/R6 cell",
                     int'(line_out), int'(e));
            end
            if (k < XFER_CELLS - 1) repeat (HALF) @(negedge clk);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check(!line_en && !line_out && !busy && !xfer_ok && !no_resp_err, "R1 during reset",
            int'({line_en, line_out, busy, xfer_ok, no_resp_err}), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(!line_en && !line_out && !busy && !xfer_ok && !no_resp_err, "R1 after reset",
            int'({line_en, line_out, busy, xfer_ok, no_resp_err}), 0);

      // Transfer A: stray status and start while sending (R8, R9), then timeout (R10).
      drive_xfer(5'h05, 5'h0A, 5'd2, 16'h4142, 16'h0001, 16'd4);     // at E0+0.5
      check(busy && line_en, "R8 start accepted when idle", int'(busy), 1);
      repeat (1000) @(negedge clk);
      status_rcvd = 1'b1;                                              // sampled at E0+1001
      @(negedge clk);
      status_rcvd = 1'b0;
      check(busy && line_en, "R9 status ignored while sending", int'(busy), 1);
      rt_addr = 5'h1B; sub_addr = 5'h03; payload = 32'hDEAD_BEEF; start = 1'b1;
      @(negedge clk);                                                  // E0+1002.5
      start = 1'b0;
      repeat (XFER_CLKS - 1003) @(negedge clk);                        // E0+2999.5
      check(line_en === 1'b1, "R7 line_en through last cell", int'(line_en), 1);
      @(negedge clk);                                                  // E0+3000.5
      check(!line_en && !line_out && busy, "R7 line released, waiting",
            int'({line_en, line_out, busy}), 1);
      repeat (4 * HALF - 1) @(negedge clk);                            // E0+3099.5
      check(busy && !no_resp_err, "R10 not yet expired", int'(no_resp_err), 0);
      @(negedge clk);                                                  // E0+3100.5
      check(!busy && no_resp_err, "R10 timeout flag", int'({busy, no_resp_err}), 1);
      repeat (20) @(negedge clk);
      check(no_resp_err === 1'b1 && !line_en, "R10 flag sticky", int'(no_resp_err), 1);

      // Transfer B: all-ones and all-zeros payloads; status answers (R9); flag clears (R10).
      drive_xfer(5'h1F, 5'h01, 5'h10, 16'hFFFF, 16'h0000, 16'd20);
      check(!no_resp_err && busy, "R10 flag cleared on accept", int'(no_resp_err), 0);
      repeat (XFER_CLKS + 2 * HALF - 1) @(negedge clk);                // E0+3049.5
      status_rcvd = 1'b1;                                              // sampled at E0+3050
      @(negedge clk);
      status_rcvd = 1'b0;
      check(xfer_ok && !busy && !no_resp_err, "R9 status ends transfer",
            int'({xfer_ok, busy, no_resp_err}), 4);
      @(negedge clk);
      check(!xfer_ok && !busy, "R9 xfer_ok single cycle", int'(xfer_ok), 0);

      // Transfer C: status on the expiry edge (R11).
      drive_xfer(5'h00, 5'h1F, 5'h00, 16'h8000, 16'h7FFE, 16'd3);
      repeat (XFER_CLKS + 3 * HALF - 1) @(negedge clk);                // E0+3074.5
      status_rcvd = 1'b1;                                              // sampled at E0+3075
      @(negedge clk);
      status_rcvd = 1'b0;
      check(xfer_ok && !no_resp_err && !busy, "R11 status wins over timeout",
            int'({xfer_ok, no_resp_err, busy}), 4);
      repeat (10) @(negedge clk);
      check(!no_resp_err && !busy, "R11 no late error", int'(no_resp_err), 0);
      check(exp_q.size() == 0, "R7 all cells observed", exp_q.size(), 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule